// File: doc/BRIEF.md
# USB Host Interrupt Status Unit

This block collects event pulses from a USB host controller core and keeps each one in a sticky status bit. The events are schedule overrun, done-queue writeback, start of frame, wake (resume) detection, fatal system error, frame-number wrap and root-port change. A software-requested handoff is also recorded. An enable register decides which of these events reach the host interrupt line. That register has a per-event mask and a global gate. The handoff event drives a separate management interrupt that no mask can hold back.

Software reaches the block through a 32-bit register port with four word addresses. Address 0 reads the status bits and clears them by writing 1 (write-1-to-clear). Address 1 sets enable bits. Address 2 clears enable bits. Address 3 reads the 2-bit overrun counter and takes the handoff request. The core's event side gets two extra services. The block detects edges on the frame-number top bit and on the resume line. It also exports a writeback-allowed flag, so a second done-queue writeback cannot overwrite one that software has not yet collected.

Top module: `usb_hc_irq_unit`

## Requirements
- R1: Status is read at address 0. The overrun flag is bit 0, writeback done is bit 1, start of frame is bit 2, wake is bit 3, fatal error is bit 4, frame wrap is bit 5, port change is bit 6 and handoff is bit 30. Every other bit reads as 0.
- R2: `irq` is high exactly when some status bit in 6..0 has its matching enable bit set and enable bit 31 (the global gate) is also set.
- R3: Bit 3 is set in the cycle after `resume_line` rises from 0 to 1, but not when `resume_by_sw` is high in that same cycle. A level that stays high does not set it again.
- R4: Bit 5 is set in the cycle after `frame_msb` differs from its value in the previous cycle, whether it rises or falls.
- R5: `ev_done_wb` sets bit 1. `wb_allowed` is the inverse of bit 1.
- R6: `ev_overrun` sets bit 0 and increments a 2-bit counter that wraps from 3 to 0. The counter is output on `ovr_count` and reads back in bits 1..0 at address 3.
- R7: `ev_sof` sets bit 2 in the following cycle. `ev_fatal` sets bit 4. `ev_port_chg` sets bit 6.
- R8: Writing a 1 to bit 0 at address 3 sets bit 30. `mgmt_irq` follows bit 30 whatever the enables hold. When HANDOFF_EN is 0, bit 30 stays 0.
- R9: At address 0, writing 1 to a bit clears it and writing 0 leaves it as it is. If an event and a clear land on the same bit in the same cycle, the bit stays set.
- R10: At address 1, each 1 in the written word sets that enable bit. At address 2, each 1 clears it. Addresses 1 and 2 both read the enable register. Only bits 31 and 6..0 are implemented; the rest read as 0.
- R11: After reset, status, enables and the counter are all 0 and `wb_allowed` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ev_overrun | input | 1 | Schedule overrun pulse |
| ev_done_wb | input | 1 | Done-queue writeback completed |
| ev_sof | input | 1 | Start-of-frame token request |
| ev_fatal | input | 1 | Fatal system error |
| ev_port_chg | input | 1 | Root-port status changed |
| frame_msb | input | 1 | Top bit of the frame counter |
| resume_line | input | 1 | Resume signalling seen on the bus |
| resume_by_sw | input | 1 | Controller is driving resume at software's request |
| irq | output | 1 | Host interrupt |
| mgmt_irq | output | 1 | Unmasked management interrupt |
| wb_allowed | output | 1 | Core may write back the done queue |
| ovr_count | output | 2 | Overrun counter |

## Verification
The checks assume that the core obeys `wb_allowed`, which means `ev_done_wb` is never raised while bit 1 is pending. The stimulus draws that event only when the bench model shows bit 1 clear. The frame-wrap check compares `frame_msb` with its value one cycle earlier, so the bench holds `frame_msb` low through reset, which matches the edge detector's reset value. The random phase toggles the frame bit and the resume line only now and then. Each of those edges is therefore separated by quiet cycles, in which the absence of a re-trigger can be seen.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int REG_W = 32;

    // status / enable bit positions (software decodes these)
    localparam int BIT_OVRUN   = 0;
    localparam int BIT_DONEWB  = 1;
    localparam int BIT_FRAME   = 2;
    localparam int BIT_WAKE    = 3;
    localparam int BIT_FATAL   = 4;
    localparam int BIT_FNWRAP  = 5;
    localparam int BIT_PORTCHG = 6;
    localparam int BIT_HANDOFF = 30;
    localparam int BIT_GLOBAL  = 31;

    localparam logic [REG_W-1:0] EVT_MASK = 32'h0000_007F;
    localparam logic [REG_W-1:0] EN_MASK  = EVT_MASK | (32'h1 << BIT_GLOBAL);

    typedef enum logic [1:0] {
        A_STATUS = 2'd0,
        A_EN_SET = 2'd1,
        A_EN_CLR = 2'd2,
        A_CMD    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic msb;
        logic res;
    } qual_st_t;

endpackage

// File: rtl/usb_irq_evt_qual.sv
module usb_irq_evt_qual
    import usb_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_msb,
    input  logic resume_line,
    input  logic resume_by_sw,
    output logic wrap_pulse,
    output logic wake_pulse
);

    qual_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.msb   = frame_msb;
        st_d.res   = resume_line;
        // either direction of the top frame bit counts
        wrap_pulse = frame_msb ^ st_q.msb;
        // only a fresh rise that the controller did not cause itself
        wake_pulse = resume_line & ~st_q.res & ~resume_by_sw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
    import usb_irq_pkg::*;
#(
    parameter int OVR_W      = 2,
    parameter bit HANDOFF_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    input  logic             ovr_ev,
    output logic [REG_W-1:0] stat,
    output logic [OVR_W-1:0] cnt
);

    localparam logic [REG_W-1:0] IMPL =
        HANDOFF_EN ? (EVT_MASK | (32'h1 << BIT_HANDOFF)) : EVT_MASK;

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [OVR_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < REG_W; i++) begin
            if (IMPL[i]) st_d.stat[i] = set_vec[i] | (st_q.stat[i] & ~clr_vec[i]);
            else         st_d.stat[i] = 1'b0;
        end
        if (ovr_ev) st_d.cnt = st_q.cnt + OVR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
    assign cnt  = st_q.cnt;

endmodule

// File: rtl/usb_irq_enable.sv
module usb_irq_enable
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] en
);

    logic [REG_W-1:0] en_d, en_q;

    always_comb begin
        en_d = ((en_q | set_vec) & ~clr_vec) & EN_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en = en_q;

endmodule

// File: rtl/usb_hc_irq_unit.sv
module usb_hc_irq_unit
    import usb_irq_pkg::*;
#(
    parameter int OVR_W      = 2,
    parameter bit HANDOFF_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ev_overrun,
    input  logic              ev_done_wb,
    input  logic              ev_sof,
    input  logic              ev_fatal,
    input  logic              ev_port_chg,
    input  logic              frame_msb,
    input  logic              resume_line,
    input  logic              resume_by_sw,
    output logic              irq,
    output logic              mgmt_irq,
    output logic              wb_allowed,
    output logic [OVR_W-1:0]  ovr_count
);

    logic             wrap_pulse, wake_pulse;
    logic [REG_W-1:0] st_set, st_clr, en_set, en_clr;
    logic [REG_W-1:0] stat_w, en_w;
    logic [OVR_W-1:0] cnt_w;

    usb_irq_evt_qual u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_msb    (frame_msb),
        .resume_line  (resume_line),
        .resume_by_sw (resume_by_sw),
        .wrap_pulse   (wrap_pulse),
        .wake_pulse   (wake_pulse)
    );

    always_comb begin
        st_set              = '0;
        st_set[BIT_OVRUN]   = ev_overrun;
        st_set[BIT_DONEWB]  = ev_done_wb;
        st_set[BIT_FRAME]   = ev_sof;
        st_set[BIT_WAKE]    = wake_pulse;
        st_set[BIT_FATAL]   = ev_fatal;
        st_set[BIT_FNWRAP]  = wrap_pulse;
        st_set[BIT_PORTCHG] = ev_port_chg;
        st_set[BIT_HANDOFF] = reg_wr && (reg_addr == A_CMD) && reg_wdata[0];
        st_clr = (reg_wr && reg_addr == A_STATUS) ? reg_wdata : '0;
        en_set = (reg_wr && reg_addr == A_EN_SET) ? reg_wdata : '0;
        en_clr = (reg_wr && reg_addr == A_EN_CLR) ? reg_wdata : '0;
    end

    usb_irq_status #(
        .OVR_W      (OVR_W),
        .HANDOFF_EN (HANDOFF_EN)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (st_set),
        .clr_vec (st_clr),
        .ovr_ev  (ev_overrun),
        .stat    (stat_w),
        .cnt     (cnt_w)
    );

    usb_irq_enable u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (en_set),
        .clr_vec (en_clr),
        .en      (en_w)
    );

    always_comb begin
        unique case (reg_addr)
            A_STATUS:          reg_rdata = stat_w;
            A_EN_SET, A_EN_CLR: reg_rdata = en_w;
            default:           reg_rdata = {{(REG_W-OVR_W){1'b0}}, cnt_w};
        endcase
    end

    assign irq        = en_w[BIT_GLOBAL] & |(stat_w & en_w & EVT_MASK);
    assign wb_allowed = ~stat_w[BIT_DONEWB];
    assign ovr_count  = cnt_w;

    generate
        if (HANDOFF_EN) begin : g_mgmt
            assign mgmt_irq = stat_w[BIT_HANDOFF];
        end else begin : g_no_mgmt
            assign mgmt_irq = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/usb_hc_irq_chk.sv
module usb_hc_irq_chk
    import usb_irq_pkg::*;
#(
    parameter int OVR_W      = 2,
    parameter bit HANDOFF_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              ev_overrun,
    input logic              ev_done_wb,
    input logic              ev_sof,
    input logic              frame_msb,
    input logic              resume_by_sw,
    input logic [REG_W-1:0]  stat,
    input logic [REG_W-1:0]  en,
    input logic              irq,
    input logic              mgmt_irq,
    input logic              wb_allowed,
    input logic [OVR_W-1:0]  ovr_count
);

    localparam logic [REG_W-1:0] STAT_OK = EVT_MASK | (32'h1 << BIT_HANDOFF);

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stat & ~STAT_OK) == '0);

    p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> en[BIT_GLOBAL]);

    p_irq_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sof && en[BIT_GLOBAL] && en[BIT_FRAME] && !reg_wr) |=> irq);

    p_wake_sw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat[BIT_WAKE] && resume_by_sw && !reg_wr) |=> !stat[BIT_WAKE]);

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_msb != $past(frame_msb)) |=> stat[BIT_FNWRAP]);

    p_wb_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done_wb |=> !wb_allowed);

    p_ovr_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overrun |=> ovr_count == OVR_W'($past(ovr_count) + OVR_W'(1)));

    p_sof_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sof |=> stat[BIT_FRAME]);

    p_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (HANDOFF_EN && reg_wr && reg_addr == A_CMD && reg_wdata[0]) |=> mgmt_irq);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[BIT_OVRUN] && !(reg_wr && reg_addr == A_STATUS && reg_wdata[BIT_OVRUN]))
        |=> stat[BIT_OVRUN]);

    p_en_impl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en & ~EN_MASK) == '0);

endmodule

bind usb_hc_irq_unit usb_hc_irq_chk #(
    .OVR_W      (OVR_W),
    .HANDOFF_EN (HANDOFF_EN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .ev_overrun   (ev_overrun),
    .ev_done_wb   (ev_done_wb),
    .ev_sof       (ev_sof),
    .frame_msb    (frame_msb),
    .resume_by_sw (resume_by_sw),
    .stat         (stat_w),
    .en           (en_w),
    .irq          (irq),
    .mgmt_irq     (mgmt_irq),
    .wb_allowed   (wb_allowed),
    .ovr_count    (ovr_count)
);

// File: tb/sim_usb_hc_irq_unit.sv
`timescale 1ns/1ps
module sim_usb_hc_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        d_wr = 1'b0;
    logic [1:0]  d_addr = 2'd0;
    logic [31:0] d_wdata = '0;
    logic        d_ovr = 1'b0, d_wb = 1'b0, d_sof = 1'b0, d_fatal = 1'b0, d_port = 1'b0;
    logic        d_msb = 1'b0, d_res = 1'b0, d_sw = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq, mgmt_irq, wb_allowed;
    logic [1:0]  ovr_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] m_stat = '0, m_en = '0;
    logic [1:0]  m_cnt = '0;
    logic        m_msb = 1'b0, m_res = 1'b0;

    always #2 clk = ~clk;

    usb_hc_irq_unit u0 (
        .clk (clk), .rst_n (rst_n),
        .reg_wr (d_wr), .reg_addr (d_addr), .reg_wdata (d_wdata), .reg_rdata (reg_rdata),
        .ev_overrun (d_ovr), .ev_done_wb (d_wb), .ev_sof (d_sof), .ev_fatal (d_fatal),
        .ev_port_chg (d_port), .frame_msb (d_msb), .resume_line (d_res),
        .resume_by_sw (d_sw), .irq (irq), .mgmt_irq (mgmt_irq),
        .wb_allowed (wb_allowed), .ovr_count (ovr_count)
    );

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:       return m_stat;
            2'd1, 2'd2: return m_en;
            default:    return {30'b0, m_cnt};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2 irq", {31'b0, irq}, {31'b0, m_en[31] & |(m_stat & m_en & 32'h7F)});
        chk("R8 mgmt_irq", {31'b0, mgmt_irq}, {31'b0, m_stat[30]});
        chk("R5 wb_allowed", {31'b0, wb_allowed}, {31'b0, ~m_stat[1]});
        chk("R6 ovr_count", {30'b0, ovr_count}, {30'b0, m_cnt});
        chk("R1 rdata", reg_rdata, exp_rd(d_addr));
    endtask

    // advance one clock; model next state from the driven inputs
    task automatic tick();
        logic [31:0] set, clr, ns, ne;
        set = '0;
        set[0] = d_ovr; set[1] = d_wb; set[2] = d_sof;
        set[3] = d_res & ~m_res & ~d_sw;
        set[4] = d_fatal; set[5] = d_msb ^ m_msb; set[6] = d_port;
        set[30] = d_wr && d_addr == 2'd3 && d_wdata[0];
        clr = (d_wr && d_addr == 2'd0) ? d_wdata : '0;
        ns = ((m_stat & ~clr) | set) & 32'h4000_007F;
        ne = m_en;
        if (d_wr && d_addr == 2'd1) ne = ne | (d_wdata & 32'h8000_007F);
        if (d_wr && d_addr == 2'd2) ne = ne & ~d_wdata;
        @(posedge clk);
        @(negedge clk);
        m_stat = ns; m_en = ne & 32'h8000_007F;
        if (d_ovr) m_cnt = m_cnt + 2'd1;
        m_msb = d_msb; m_res = d_res;
        check_all();
    endtask

    task automatic idle();
        d_wr = 1'b0; d_ovr = 1'b0; d_wb = 1'b0; d_sof = 1'b0;
        d_fatal = 1'b0; d_port = 1'b0; d_sw = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        d_wr = 1'b1; d_addr = a; d_wdata = v;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11 status", reg_rdata, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);
        chk("R11 wb_allowed", {31'b0, wb_allowed}, 32'h1);
        chk("R11 count", {30'b0, ovr_count}, 32'h0);

        // R7: start of frame
        idle(); d_sof = 1'b1; tick();
        chk("R7 sof bit", reg_rdata, 32'h4);
        chk("R2 masked", {31'b0, irq}, 32'h0);

        // R10 / R2: enable set and clear
        idle(); wr(2'd1, 32'h4); tick();
        idle(); tick();
        chk("R10 en set", reg_rdata, 32'h4);
        chk("R2 no global", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'h8000_0000); tick();
        idle(); tick();
        chk("R2 global on", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h4); tick();
        idle(); tick();
        chk("R10 en clear", reg_rdata, 32'h8000_0000);
        chk("R2 bit masked", {31'b0, irq}, 32'h0);

        // R9: write-one-to-clear, event wins
        idle(); d_addr = 2'd0; tick();
        wr(2'd0, 32'h4); d_sof = 1'b1; tick();
        chk("R9 event wins", reg_rdata, 32'h4);
        idle(); wr(2'd0, 32'h0); tick();
        chk("R9 zero write", reg_rdata, 32'h4);
        wr(2'd0, 32'h4); tick();
        chk("R9 cleared", reg_rdata, 32'h0);

        // R4: frame wrap both directions
        idle(); d_msb = 1'b1; tick();
        chk("R4 rise", reg_rdata, 32'h20);
        wr(2'd0, 32'h20); tick();
        idle(); tick();
        chk("R4 steady", reg_rdata, 32'h0);
        d_msb = 1'b0; tick();
        chk("R4 fall", reg_rdata, 32'h20);
        wr(2'd0, 32'h20); tick();

        // R3: wake edge qualification
        idle(); d_res = 1'b1; d_sw = 1'b1; tick();
        chk("R3 sw resume", reg_rdata, 32'h0);
        idle(); d_res = 1'b0; tick();
        d_res = 1'b1; tick();
        chk("R3 rise", reg_rdata, 32'h8);
        wr(2'd0, 32'h8); tick();
        idle(); tick();
        chk("R3 level", reg_rdata, 32'h0);

        // R6: overrun counter wraps
        idle(); d_ovr = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        idle(); tick();
        chk("R6 wrap", {30'b0, ovr_count}, 32'h1);
        chk("R6 bit", reg_rdata, 32'h1);
        wr(2'd0, 32'h1); tick();

        // R5: writeback gating
        idle(); d_wb = 1'b1; tick();
        chk("R5 blocked", {31'b0, wb_allowed}, 32'h0);
        idle(); tick();
        wr(2'd0, 32'h2); tick();
        chk("R5 released", {31'b0, wb_allowed}, 32'h1);

        // R8: handoff request drives unmasked management interrupt
        idle(); wr(2'd3, 32'h1); tick();
        chk("R8 mgmt", {31'b0, mgmt_irq}, 32'h1);
        chk("R8 irq unaffected", {31'b0, irq}, 32'h0);
        idle(); d_addr = 2'd0; tick();
        chk("R1 handoff bit", reg_rdata, 32'h4000_0000);
        wr(2'd0, 32'h4000_0000); tick();

        // R1: all events at once, layout
        idle(); d_res = 1'b0; tick();
        d_ovr = 1'b1; d_wb = 1'b1; d_sof = 1'b1; d_fatal = 1'b1; d_port = 1'b1;
        d_msb = 1'b1; d_res = 1'b1; tick();
        chk("R1 layout", reg_rdata, 32'h7F);
        idle(); wr(2'd0, 32'hFFFF_FFFF); tick();
        chk("R1 all clear", reg_rdata, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF); tick();
        chk("R10 impl bits", reg_rdata, 32'h8000_007F);
        wr(2'd2, 32'hFFFF_FFFF); tick();

        // random phase
        for (int c = 0; c < 3000; c++) begin
            idle();
            d_addr = 2'($urandom % 4);
            if ($urandom % 4 == 0) begin
                d_wr = 1'b1;
                d_wdata = $urandom & $urandom;
            end
            d_ovr   = ($urandom % 8) == 0;
            d_sof   = ($urandom % 8) == 0;
            d_fatal = ($urandom % 16) == 0;
            d_port  = ($urandom % 8) == 0;
            d_wb    = !m_stat[1] && (($urandom % 6) == 0);
            d_sw    = ($urandom % 4) == 0;
            if ($urandom % 16 == 0) d_msb = ~d_msb;
            if ($urandom % 8 == 0)  d_res = ~d_res;
            tick();
        end

        done = 1'b1;
        finish_run();
    end

endmodule